// File: doc/BRIEF.md
# Two-wire slave command decoder

This block is the command side of a two-wire serial bus slave. It watches the bus on two oversampled inputs and looks for write transfers addressed to its own 7-bit address. Each such write carries one or two command bytes. The top bit of every command byte chooses where the byte goes: into the setup register or into the configuration register. There is no separate register pointer.

The slave acknowledges by pulling SDA low through an open-drain enable. The stored command bytes, and the fields decoded from them, go out on parallel outputs to a conversion controller.

A read addressed to the slave is acknowledged and then handed off as a one-cycle request pulse. The slave stays silent on the bus until the next start or stop.

Top module: `twowire_cmd_slave`

## Requirements
- R1: After reset the setup register holds 8'h80 and the configuration register holds 8'h60. This means internal conversion clock (`ext_clk` = 0) and scan field 2'b11 (single channel). `sda_oe` and `read_req` are 0.
- R2: Both bus inputs pass through a two-flop synchronizer. A falling SDA while SCL is high is a start. A rising SDA while SCL is high is a stop. A stop in the middle of a byte abandons the transfer with no register change.
- R3: The address byte is 7 address bits, MSB first, then the R/W bit (0 = write). On a match the slave drives `sda_oe` high for the ninth clock.
- R4: An address that does not match gets no acknowledge. Every byte after it, up to the next start, is neither acknowledged nor stored.
- R5: A data byte with bit 7 = 1 is stored whole in the setup register. A data byte with bit 7 = 0 is stored whole in the configuration register. Each stored byte is acknowledged.
- R6: At most two data bytes are accepted per write. A third byte is not acknowledged and not stored.
- R7: A repeated start returns the slave to address reception and keeps the values already written.
- R8: A matching address with R/W = 1 is acknowledged and raises `read_req` for exactly one clock. The slave then keeps SDA released and changes no register.
- R9: `ext_clk` is setup bit 3, `ref_sel` is setup bit 5, and `scan_mode` is configuration bits 6:5.
- R10: `sda_oe` is 0 while the master is driving data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| setup_q | output | 8 | Stored setup byte |
| config_q | output | 8 | Stored configuration byte |
| ext_clk | output | 1 | 1 selects the external conversion clock |
| ref_sel | output | 1 | Reference-pin select |
| scan_mode | output | 2 | Scan-mode field |
| read_req | output | 1 | One-cycle pulse when a read to this slave is acknowledged |

## Verification
The bench targets these corner cases:
- **Byte routing by the top bit.** A slave that decoded the wrong bit would put configuration bytes into the setup register.
- **Third data byte.** A slave without a byte limit would acknowledge the third byte and overwrite a register.
- **Foreign address.** Its data bytes carry patterns that a wrongly matching slave would store, and the scoreboard reports that as an unexpected update.
- **Repeated start.** A slave that lost state on a repeated start would fail the second address acknowledge.
- **Read-direction address.** A slave that treated it as a write would store the clocked bits.
- **Stop in mid-byte.** A slave that kept counting bits through the stop would misalign the next transfer.

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h4D,
  parameter logic [7:0] SETUP_INIT  = 8'h80,
  parameter logic [7:0] CONFIG_INIT = 8'h60,
  parameter int         MAX_BYTES   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [7:0] setup_q,
  output logic [7:0] config_q,
  output logic       ext_clk,
  output logic       ref_sel,
  output logic [1:0] scan_mode,
  output logic       read_req
);

  localparam int BCW = $clog2(MAX_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_READ, S_SKIP} st_t;

  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_now, sda_old;
  logic start_c, stop_c, rise, fall;
  st_t st;
  logic [3:0] nbit;
  logic [7:0] shreg;
  logic [BCW-1:0] nbyte;
  logic is_rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_in};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_in};
    end

  assign scl_now = scl_p[SYNC_STAGES-1];
  assign scl_old = scl_p[SYNC_STAGES];
  assign sda_now = sda_p[SYNC_STAGES-1];
  assign sda_old = sda_p[SYNC_STAGES];

  assign start_c = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_c  = scl_now & scl_old & ~sda_old & sda_now;
  assign rise    = scl_now & ~scl_old;
  assign fall    = ~scl_now & scl_old;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      nbit     <= '0;
      shreg    <= '0;
      nbyte    <= '0;
      is_rd    <= 1'b0;
      sda_oe   <= 1'b0;
      read_req <= 1'b0;
      setup_q  <= SETUP_INIT;
      config_q <= CONFIG_INIT;
    end else begin
      read_req <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        nbit   <= '0;
        nbyte  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_DATA: begin
            if (rise) begin
              shreg <= {shreg[6:0], sda_now};
              nbit  <= nbit + 4'd1;
            end else if (fall && nbit == 4'd8) begin
              nbit <= '0;
              if (st == S_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  st       <= S_AACK;
                  is_rd    <= shreg[0];
                  read_req <= shreg[0];
                end else begin
                  st <= S_SKIP;
                end
              end else if (nbyte == BCW'(MAX_BYTES)) begin
                st <= S_SKIP;
              end else begin
                sda_oe <= 1'b1;
                st     <= S_DACK;
                nbyte  <= nbyte + BCW'(1);
                if (shreg[7]) setup_q  <= shreg;
                else          config_q <= shreg;
              end
            end
          end
          S_AACK, S_DACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              st     <= (st == S_AACK && is_rd) ? S_READ : S_DATA;
            end
          end
          default: ;
        endcase
      end
    end

  assign ext_clk   = setup_q[3];
  assign ref_sel   = setup_q[5];
  assign scan_mode = config_q[6:5];

endmodule

module twowire_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       read_req,
  input logic [7:0] setup_q,
  input logic [7:0] config_q
);

  p_setup_write_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_q != $past(setup_q)) |-> (sda_oe && !$past(sda_oe)));

  p_config_write_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (config_q != $past(config_q)) |-> (sda_oe && !$past(sda_oe)));

  p_route_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    setup_q[7] && !config_q[7]);

  p_read_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    read_req |=> !read_req);

  p_read_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    read_req |-> (sda_oe && !$past(sda_oe)));

endmodule

bind twowire_cmd_slave twowire_cmd_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .read_req(read_req),
  .setup_q(setup_q), .config_q(config_q));

// File: tb/test_twowire_cmd_slave.sv
module test_twowire_cmd_slave;
  localparam logic [6:0] ADDR = 7'h4D;
  localparam int Q = 40;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, ext_clk, ref_sel, read_req;
  logic [7:0] setup_q, config_q;
  logic [1:0] scan_mode;

  assign sda_bus = sda_m & ~sda_oe;

  twowire_cmd_slave i_twowire_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .setup_q(setup_q), .config_q(config_q),
    .ext_clk(ext_clk), .ref_sel(ref_sel), .scan_mode(scan_mode),
    .read_req(read_req));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [9:0] expq[$];
  logic [7:0] m_setup = 8'h80, m_cfg = 8'h60;
  logic [7:0] ps, pc;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pop_cmp(input logic [9:0] got, input string tag);
    logic [9:0] e;
    if (expq.size() == 0) chk(1'b0, {tag, " unexpected"}, {6'd0, got}, 16'h0);
    else begin
      e = expq.pop_front();
      chk(e == got, tag, {6'd0, got}, {6'd0, e});
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      ps = setup_q;
      pc = config_q;
    end else begin
      if (setup_q != ps)  pop_cmp({2'd1, setup_q}, "R5 setup update");
      if (config_q != pc) pop_cmp({2'd2, config_q}, "R5 config update");
      if (read_req)       pop_cmp({2'd3, 8'h00}, "R8 read request");
      ps = setup_q;
      pc = config_q;
    end
  end

  task automatic bus_start;
    scl_m = 0; #Q sda_m = 1; #Q scl_m = 1; #Q sda_m = 0; #Q scl_m = 0; #Q;
  endtask

  task automatic bus_stop;
    scl_m = 0; #Q sda_m = 0; #Q scl_m = 1; #Q sda_m = 1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      #Q scl_m = 1;
      #Q if (i == 4) chk(sda_oe == 1'b0, "R10 released in data bit", {15'd0, sda_oe}, 16'h0);
      #Q scl_m = 0;
      #Q;
    end
    sda_m = 1;
    #Q scl_m = 1;
    #Q chk((sda_bus == 1'b0) == exp_ack, tag, {15'd0, ~sda_bus}, {15'd0, exp_ack});
    #Q scl_m = 0;
    #Q;
  endtask

  task automatic wr_data(input logic [7:0] b, input bit stored, input string tag);
    if (stored) begin
      if (b[7]) begin
        if (b != m_setup) expq.push_back({2'd1, b});
        m_setup = b;
      end else begin
        if (b != m_cfg) expq.push_back({2'd2, b});
        m_cfg = b;
      end
    end
    send_byte(b, stored, tag);
  endtask

  task automatic check_regs(input string tag);
    chk(setup_q == m_setup, {tag, " setup"}, {8'd0, setup_q}, {8'd0, m_setup});
    chk(config_q == m_cfg, {tag, " config"}, {8'd0, config_q}, {8'd0, m_cfg});
    chk(ext_clk == m_setup[3], "R9 ext_clk", {15'd0, ext_clk}, {15'd0, m_setup[3]});
    chk(ref_sel == m_setup[5], "R9 ref_sel", {15'd0, ref_sel}, {15'd0, m_setup[5]});
    chk(scan_mode == m_cfg[6:5], "R9 scan_mode", {14'd0, scan_mode}, {14'd0, m_cfg[6:5]});
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100 rst_n = 1;
    #50;
    // R1 reset state
    chk(setup_q == 8'h80, "R1 setup reset", {8'd0, setup_q}, 16'h80);
    chk(config_q == 8'h60, "R1 config reset", {8'd0, config_q}, 16'h60);
    chk(ext_clk == 1'b0, "R1 internal clock", {15'd0, ext_clk}, 16'h0);
    chk(scan_mode == 2'b11, "R1 single channel", {14'd0, scan_mode}, 16'h3);
    chk(sda_oe == 1'b0 && read_req == 1'b0, "R1 outputs idle", {14'd0, sda_oe, read_req}, 16'h0);

    // R3 R5 one-byte write
    bus_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
    wr_data(8'h88, 1'b1, "R5 setup byte ack");
    bus_stop;
    check_regs("R5 one byte");

    // R5 R6 two-byte write
    bus_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
    wr_data(8'h20, 1'b1, "R5 config byte ack");
    wr_data(8'hA0, 1'b1, "R6 second byte ack");
    bus_stop;
    check_regs("R6 two bytes");

    // R4 foreign address
    bus_start;
    send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, "R4 no address ack");
    send_byte(8'h8F, 1'b0, "R4 byte ignored");
    send_byte(8'h7F, 1'b0, "R4 byte ignored");
    bus_stop;
    check_regs("R4 unchanged");

    // R6 third byte refused
    bus_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
    wr_data(8'h40, 1'b1, "R5 config byte ack");
    wr_data(8'h98, 1'b1, "R5 setup byte ack");
    wr_data(8'h00, 1'b0, "R6 third byte nack");
    bus_stop;
    check_regs("R6 third byte dropped");

    // R7 repeated start
    bus_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R3 address ack");
    wr_data(8'hC0, 1'b1, "R5 setup byte ack");
    bus_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R7 address ack after repeated start");
    wr_data(8'h60, 1'b1, "R7 byte after repeated start");
    bus_stop;
    check_regs("R7 values kept");

    // R8 read direction
    bus_start;
    expq.push_back({2'd3, 8'h00});
    send_byte({ADDR, 1'b1}, 1'b1, "R8 read address ack");
    send_byte(8'hFF, 1'b0, "R8 bus released in read");
    bus_stop;
    check_regs("R8 no register change");

    // R2 stop in mid-byte, then a clean write
    bus_start;
    for (int i = 7; i >= 4; i--) begin
      sda_m = ADDR[i-1];
      #Q scl_m = 1; #(2*Q) scl_m = 0; #Q;
    end
    bus_stop;
    chk(sda_oe == 1'b0, "R2 released after abort", {15'd0, sda_oe}, 16'h0);
    check_regs("R2 aborted transfer");
    bus_start;
    send_byte({ADDR, 1'b0}, 1'b1, "R2 address ack after abort");
    wr_data(8'h8A, 1'b1, "R2 setup byte after abort");
    bus_stop;
    check_regs("R2 write after abort");

    #200;
    chk(expq.size() == 0, "R5 all expected updates seen", 16'(expq.size()), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule